// File: doc/BRIEF.md
# Dominant Bridging Fault Injector

This block places a chain of two-input OR gates over a row of neighbouring signal lines. With the default configuration of three lines, the fault-free outputs are Z1 = x1 + x2 and Z2 = x2 + x3, with the middle line shared by both gates. Beside the fault-free copy, the block builds a second, faulty copy of the same gates. In the faulty copy, two adjacent lines may be shorted together.

A two-bit mode input chooses how the short resolves:
- **No bridge.** The lines keep their driven values.
- **Wired-AND bridge.** A 0 dominates, so both shorted lines take the AND of their driven values.
- **Wired-OR bridge.** A 1 dominates, so both shorted lines take the OR of their driven values.

Because the resolved value replaces both lines, a single defect can corrupt both outputs at once.

The line values and the mode are captured on a clock edge. Both output copies and a mismatch flag for each output follow combinationally from the captured values. A test environment can use the block to see which input patterns expose a given bridge.

Top module: `bridge_fault_injector`

## Requirements
- R1: A synchronous active-low reset clears the captured lines and the captured mode. While reset holds and in the cycle after it, every good output, faulty output and mismatch flag reads 0.
- R2: One clock edge after inputs are applied, good output i equals line i OR line i+1. Line 0 is x1, line 1 is x2 and line 2 is x3.
- R3: Mode code 2'b00 means no bridge, and the faulty outputs then equal the good outputs for all 8 input patterns.
- R4: Mode code 2'b01 is a wired-AND bridge. Both bridged lines take the AND of their driven values, so a faulty output can never be 1 where the good output is 0.
- R5: Mode code 2'b10 is a wired-OR bridge. Both bridged lines take the OR of their driven values, so a faulty output can never be 0 where the good output is 1.
- R6: Only the two adjacent lines at the bridge position (by default lines 0 and 1, that is x1 and x2) are affected. Every other line, including x3, keeps its driven value in the faulty copy.
- R7: Mismatch flag i is 1 exactly when faulty output i differs from good output i. It can only be 1 in the wired-AND or wired-OR mode.
- R8: In the default configuration with the wired-AND bridge, the faulty outputs are Z1 = x1·x2 and Z2 = x1·x2 + x3.
- R9: Mode code 2'b11 is treated exactly as no bridge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_in | input | LINES | Driven line values, bit 0 = x1 |
| mode_in | input | 2 | Bridge mode: 00 none, 01 wired-AND, 10 wired-OR, 11 none |
| z_good | output | LINES-1 | Fault-free OR outputs, bit 0 = Z1 |
| z_fault | output | LINES-1 | Outputs with the bridge applied |
| z_mismatch | output | LINES-1 | Per-output difference flag |

## Verification
The assertions check four properties on every cycle:
- With no bridge selected, or with code 11, the faulty outputs track the good outputs.
- A wired-AND bridge only ever pulls an output down.
- A wired-OR bridge only ever pulls an output up.
- A mismatch flag never rises without an active bridge.

Some behaviours can only be shown by the bench's exhaustive sweep of all 8 line patterns under all four mode codes:
- the exact faulty formulas;
- that x3 keeps its driven value;
- the one-cycle capture latency;
- the cleared state after reset.

// File: rtl/brg_pkg.sv
// Package: shared mode type for the bridging fault injector.
// Assumes a two-bit mode code; code 11 is reserved and behaves as no bridge.
package brg_pkg;
    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_AND  = 2'b01,
        BR_OR   = 2'b10,
        BR_RSVD = 2'b11
    } bridge_mode_e;
endpackage

// File: rtl/brg_capture.sv
// Module: brg_capture
// Registers the driven line values and the bridge mode on each rising edge.
// Assumes a synchronous active-low reset; reset clears lines and selects no bridge.
module brg_capture
    import brg_pkg::*;
#(
    parameter int LINES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   lines_in,
    input  logic [1:0]         mode_in,
    output logic [LINES-1:0]   lines_q,
    output bridge_mode_e       mode_q
);
    // Capture the stimulus once per clock, clearing under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
            mode_q  <= BR_NONE;
        end else begin
            lines_q <= lines_in;
            mode_q  <= bridge_mode_e'(mode_in);
        end
    end
endmodule

// File: rtl/brg_resolve.sv
// Module: brg_resolve
// Replaces two adjacent lines, BLO and BLO+1, by their resolved bridge value.
// Assumes 0 <= BLO <= LINES-2; all other lines pass through unchanged.
module brg_resolve
    import brg_pkg::*;
#(
    parameter int LINES = 3,
    parameter int BLO   = 0
) (
    input  logic [LINES-1:0] lines,
    input  bridge_mode_e     mode,
    output logic [LINES-1:0] lines_f
);
    localparam int BHI = BLO + 1;

    logic node_v;

    // Resolve the shorted node according to the dominance rule and drive both lines with it.
    always_comb begin
        lines_f = lines;
        node_v  = lines[BLO];
        case (mode)
            BR_AND: begin
                node_v       = lines[BLO] & lines[BHI];
                lines_f[BLO] = node_v;
                lines_f[BHI] = node_v;
            end
            BR_OR: begin
                node_v       = lines[BLO] | lines[BHI];
                lines_f[BLO] = node_v;
                lines_f[BHI] = node_v;
            end
            default: begin
                node_v = lines[BLO];
            end
        endcase
    end
endmodule

// File: rtl/brg_or_chain.sv
// Module: brg_or_chain
// Builds one two-input OR gate for each pair of neighbouring lines.
// Assumes LINES >= 2; output i is line i OR line i+1.
module brg_or_chain #(
    parameter int LINES = 3,
    parameter int NOUT  = LINES - 1
) (
    input  logic [LINES-1:0] lines,
    output logic [NOUT-1:0]  z
);
    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        // One OR gate over a neighbouring line pair.
        always_comb z[g] = lines[g] | lines[g+1];
    end
endmodule

// File: rtl/brg_compare.sv
// Module: brg_compare
// Flags, bit by bit, where the faulty vector differs from the good vector.
// Assumes both vectors are the same width; purely combinational.
module brg_compare #(
    parameter int W = 2
) (
    input  logic [W-1:0] good,
    input  logic [W-1:0] bad,
    output logic [W-1:0] diff
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        // Per-output difference detector.
        always_comb diff[g] = good[g] != bad[g];
    end
endmodule

// File: rtl/bridge_fault_injector.sv
// Module: bridge_fault_injector (top)
// Captures driven lines and a bridge mode, then produces fault-free and bridged OR-chain
// outputs with per-output mismatch flags. Assumes BRIDGE_LO selects an adjacent pair.
module bridge_fault_injector
    import brg_pkg::*;
#(
    parameter int LINES     = 3,
    parameter int BRIDGE_LO = 0,
    parameter int NOUT      = LINES - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] x_in,
    input  logic [1:0]       mode_in,
    output logic [NOUT-1:0]  z_good,
    output logic [NOUT-1:0]  z_fault,
    output logic [NOUT-1:0]  z_mismatch
);
    logic [LINES-1:0] lines_q;
    logic [LINES-1:0] lines_br;
    bridge_mode_e     mode_q;

    brg_capture #(.LINES(LINES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (x_in),
        .mode_in  (mode_in),
        .lines_q  (lines_q),
        .mode_q   (mode_q)
    );

    brg_resolve #(.LINES(LINES), .BLO(BRIDGE_LO)) u_res (
        .lines   (lines_q),
        .mode    (mode_q),
        .lines_f (lines_br)
    );

    brg_or_chain #(.LINES(LINES), .NOUT(NOUT)) u_good (
        .lines (lines_q),
        .z     (z_good)
    );

    brg_or_chain #(.LINES(LINES), .NOUT(NOUT)) u_bad (
        .lines (lines_br),
        .z     (z_fault)
    );

    brg_compare #(.W(NOUT)) u_cmp (
        .good (z_good),
        .bad  (z_fault),
        .diff (z_mismatch)
    );
endmodule

// File: rtl/bridge_fault_injector_chk.sv
// Module: bridge_fault_injector_chk
// Checker bound into the top; watches the captured mode against the output copies.
module bridge_fault_injector_chk
    import brg_pkg::*;
#(
    parameter int NOUT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input bridge_mode_e    mode_q,
    input logic [NOUT-1:0] z_good,
    input logic [NOUT-1:0] z_fault,
    input logic [NOUT-1:0] z_mismatch
);
    // R3 and R9: without an active bridge, the faulty copy tracks the good copy.
    a_r3_none_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_NONE || mode_q == BR_RSVD) |-> (z_fault == z_good));

    // R4: a wired-AND bridge can only pull outputs low.
    a_r4_and_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_AND) |-> ((z_fault & ~z_good) == '0));

    // R5: a wired-OR bridge can only pull outputs high.
    a_r5_or_pulls_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == BR_OR) |-> ((z_good & ~z_fault) == '0));

    // R7: a mismatch flag requires an active bridge.
    a_r7_flag_needs_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        (z_mismatch != '0) |-> (mode_q == BR_AND || mode_q == BR_OR));
endmodule

bind bridge_fault_injector bridge_fault_injector_chk #(.NOUT(NOUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .z_good     (z_good),
    .z_fault    (z_fault),
    .z_mismatch (z_mismatch)
);

// File: tb/test_bridge_fault_injector.sv
module test_bridge_fault_injector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] x_in = '0;
    logic [1:0] mode_in = '0;
    logic [1:0] z_good, z_fault, z_mismatch;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bridge_fault_injector i_bridge_fault_injector (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .mode_in(mode_in),
        .z_good(z_good), .z_fault(z_fault), .z_mismatch(z_mismatch)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with nonzero stimulus held during reset
        x_in = 3'b111; mode_in = 2'b10;
        repeat (3) @(negedge clk);
        check("R1 during reset", {z_good, z_fault, z_mismatch}, 6'b0);
        @(negedge clk); rst_n = 1'b1; x_in = 3'b000; mode_in = 2'b00;
        check("R1 first cycle after reset", {z_good, z_fault, z_mismatch}, 6'b0);

        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 8; v++) begin
                logic x1, x2, x3, l1, l2, e_g1, e_g2, e_f1, e_f2;
                logic [1:0] eg, ef;
                @(negedge clk);
                x_in = 3'(v); mode_in = 2'(m);
                @(negedge clk);
                x1 = v[0]; x2 = v[1]; x3 = v[2];
                e_g1 = x1 | x2; e_g2 = x2 | x3;
                l1 = x1; l2 = x2;
                if (m == 1) begin l1 = x1 & x2; l2 = x1 & x2; end
                if (m == 2) begin l1 = x1 | x2; l2 = x1 | x2; end
                e_f1 = l1 | l2; e_f2 = l2 | x3;   // R6: x3 keeps its driven value
                eg = {e_g2, e_g1}; ef = {e_f2, e_f1};
                check("R2 good outputs", {4'b0, z_good}, {4'b0, eg});
                case (m)
                    0: check("R3 none mode", {4'b0, z_fault}, {4'b0, eg});
                    1: begin
                        check("R4 wired-AND", {4'b0, z_fault}, {4'b0, ef});
                        check("R8 Z1=x1x2 Z2=x1x2+x3", {4'b0, z_fault},
                              {4'b0, (x1 & x2) | x3, x1 & x2});
                    end
                    2: check("R5 wired-OR R6 x3 untouched", {4'b0, z_fault}, {4'b0, ef});
                    default: check("R9 code 11 as none", {4'b0, z_fault}, {4'b0, eg});
                endcase
                check("R7 mismatch flags", {4'b0, z_mismatch}, {4'b0, eg ^ ef});
            end
        end

        // R1: reset applied mid-run clears outputs again
        @(negedge clk); x_in = 3'b111; mode_in = 2'b10; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {z_good, z_fault, z_mismatch}, 6'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule